// File: doc/BRIEF.md
# Shared Packed-Integer / Floating-Point Register File

This block holds eight 64-bit registers that serve two execution domains at once: a packed-integer SIMD unit and a floating-point stack unit. There is a single physical storage array, so a value written through one domain can be read back through the other. Every port carries a domain bit that says which unit issued the access. The block has two read ports and one write port.

Next to the data, the block keeps an occupancy tag for each entry, as seen by the floating-point side. Any packed-integer write marks every entry as occupied. A floating-point write marks only the entry it writes. A separate clear command empties all tags, and software must issue it before floating-point code runs again after packed-integer use. If a floating-point read hits an entry whose tag is empty, the block raises a stack-fault pulse and returns zero instead of the stored data.

A saturating counter records how often execution moves from one domain to the other. This shows what frequent transitions cost.

Top module: `simd_fp_regfile`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both read data outputs are zero, `stack_fault` is 0, `tag_word` is 0 (all empty) and `switch_count` is 0.
- R2: Data written through either domain is returned by a later read from either domain. Read data appears on the clock edge after the read is issued. A read issued in the same cycle as a write to the same entry returns the value held before that write.
- R3: A write with `wr_fp`=0 (packed-integer) sets all eight bits of `tag_word` to 1 (occupied).
- R4: A write with `wr_fp`=1 (floating-point) sets only bit `wr_addr` of `tag_word`. The other bits are unchanged.
- R5: `empty_cmd` clears `tag_word` to all zeros on the next edge. When a write happens in the same cycle, the clear takes effect after the write's tag update, so the tags end up empty. The write's data is still stored.
- R6: A read with domain bit 1 of an entry whose `tag_word` bit is 0 drives `stack_fault` high for exactly the following cycle, and that port's data output is zero. Tag state is the value before any update in the same cycle.
- R7: A read with domain bit 0 never causes `stack_fault`. It returns the stored data whatever the tag state.
- R8: A cycle is active when any port is enabled. Its domain is floating-point if any enabled port has its domain bit at 1, and packed-integer otherwise. `switch_count` increments by one when an active cycle's domain differs from that of the previous active cycle. The first active cycle after reset does not count. The counter saturates at all ones.
- R9: A read data output holds its previous value in the cycle after its port was not enabled.
- R10: Bit i of `tag_word` is 1 exactly when entry i is occupied for the floating-point side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_fp | input | 1 | Read port 0 domain, 1 = floating-point |
| rd0_addr | input | 3 | Read port 0 entry index |
| rd0_data | output | 64 | Read port 0 data, one cycle after request |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_fp | input | 1 | Read port 1 domain, 1 = floating-point |
| rd1_addr | input | 3 | Read port 1 entry index |
| rd1_data | output | 64 | Read port 1 data, one cycle after request |
| wr_en | input | 1 | Write enable |
| wr_fp | input | 1 | Write domain, 1 = floating-point |
| wr_addr | input | 3 | Write entry index |
| wr_data | input | 64 | Write data |
| empty_cmd | input | 1 | Clear all occupancy tags |
| tag_word | output | 8 | Occupancy tags, 1 = occupied |
| stack_fault | output | 1 | Pulse: floating-point read of an empty entry |
| switch_count | output | CNT_W | Saturating count of domain transitions |

## Verification
The hardest state to reach from the ports is a floating-point read of an empty entry while other entries are occupied. Only floating-point writes set individual tags, and any packed-integer write fills all of them. The stimulus therefore issues the clear command, makes sparse floating-point writes, and then sends floating-point reads to both occupied and empty entries. It also drives the clear together with a write, and alternates domains until the narrowed counter saturates. Random traffic weights the clear command and the domain bits so that partly filled tag words occur often.

// File: rtl/simd_fp_regfile.sv
module simd_fp_regfile #(
  parameter int N_REG = 8,
  parameter int WIDTH = 64,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(N_REG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd0_en,
  input  logic             rd0_fp,
  input  logic [AW-1:0]    rd0_addr,
  output logic [WIDTH-1:0] rd0_data,
  input  logic             rd1_en,
  input  logic             rd1_fp,
  input  logic [AW-1:0]    rd1_addr,
  output logic [WIDTH-1:0] rd1_data,
  input  logic             wr_en,
  input  logic             wr_fp,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             empty_cmd,
  output logic [N_REG-1:0] tag_word,
  output logic             stack_fault,
  output logic [CNT_W-1:0] switch_count
);

  logic [WIDTH-1:0] mem [N_REG];
  logic [N_REG-1:0] tags, tags_nx;
  logic             bad0, bad1, flt0, flt1;
  logic             act, dom, last_dom, seen;

  assign bad0 = rd0_en && rd0_fp && !tags[rd0_addr];
  assign bad1 = rd1_en && rd1_fp && !tags[rd1_addr];
  assign act  = wr_en || rd0_en || rd1_en;
  assign dom  = (wr_en && wr_fp) || (rd0_en && rd0_fp) || (rd1_en && rd1_fp);

  assign tag_word    = tags;
  assign stack_fault = flt0 || flt1;

  always_comb begin
    tags_nx = tags;
    if (wr_en) begin
      if (wr_fp) tags_nx[wr_addr] = 1'b1;
      else       tags_nx = '1;
    end
    if (empty_cmd) tags_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REG; i++) mem[i] <= '0;
      tags <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      tags <= tags_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd0_data <= '0;
      flt0     <= 1'b0;
    end else begin
      flt0 <= bad0;
      if (rd0_en) rd0_data <= bad0 ? '0 : mem[rd0_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd1_data <= '0;
      flt1     <= 1'b0;
    end else begin
      flt1 <= bad1;
      if (rd1_en) rd1_data <= bad1 ? '0 : mem[rd1_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      switch_count <= '0;
      last_dom     <= 1'b0;
      seen         <= 1'b0;
    end else if (act) begin
      seen     <= 1'b1;
      last_dom <= dom;
      if (seen && dom != last_dom && switch_count != '1)
        switch_count <= switch_count + 1'b1;
    end
  end

  p_simd_wr_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_fp && !empty_cmd) |=> (tag_word == '1));

  p_fp_wr_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fp && !empty_cmd) |=> tag_word[$past(wr_addr)]);

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    empty_cmd |=> (tag_word == '0));

  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_en && rd0_fp && !tag_word[rd0_addr]) |=> (stack_fault && rd0_data == '0));

  p_simd_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd0_en && rd0_fp) && !(rd1_en && rd1_fp)) |=> !stack_fault);

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (switch_count == $past(switch_count) ||
              switch_count == $past(switch_count) + 1'b1));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd1_en |=> $stable(rd1_data));

endmodule

// File: tb/test_simd_fp_regfile.sv
`timescale 1ns/1ps
module test_simd_fp_regfile;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic rd0_en = 0, rd0_fp = 0, rd1_en = 0, rd1_fp = 0;
  logic wr_en = 0, wr_fp = 0, empty_cmd = 0;
  logic [2:0] rd0_addr = 0, rd1_addr = 0, wr_addr = 0;
  logic [63:0] wr_data = 0, rd0_data, rd1_data;
  logic [7:0] tag_word;
  logic stack_fault;
  logic [CW-1:0] switch_count;

  always #2.5 clk = ~clk;

  simd_fp_regfile #(.CNT_W(CW)) i_simd_fp_regfile (
    .clk, .rst_n, .rd0_en, .rd0_fp, .rd0_addr, .rd0_data,
    .rd1_en, .rd1_fp, .rd1_addr, .rd1_data,
    .wr_en, .wr_fp, .wr_addr, .wr_data, .empty_cmd,
    .tag_word, .stack_fault, .switch_count);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [63:0] m_mem [8];
  logic [7:0]  m_tag;
  int          m_cnt;
  bit          m_last, m_seen;
  logic [63:0] e_rd0, e_rd1;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] next_tags(logic [7:0] t);
    logic [7:0] r = t;
    if (wr_en) r = wr_fp ? (t | (8'h1 << wr_addr)) : 8'hFF;
    if (empty_cmd) r = 8'h00;
    return r;
  endfunction

  task automatic cycle();
    bit f0, f1, act, dom, ef;
    string dl0, dl1, tl;
    f0  = rd0_en && rd0_fp && !m_tag[rd0_addr];
    f1  = rd1_en && rd1_fp && !m_tag[rd1_addr];
    ef  = f0 || f1;
    if (rd0_en) e_rd0 = f0 ? 64'd0 : m_mem[rd0_addr];
    if (rd1_en) e_rd1 = f1 ? 64'd0 : m_mem[rd1_addr];
    dl0 = !rd0_en ? "R9" : (rd0_fp ? (f0 ? "R6" : "R2") : "R7");
    dl1 = !rd1_en ? "R9" : (rd1_fp ? (f1 ? "R6" : "R2") : "R7");
    tl  = empty_cmd ? "R5" : (wr_en ? (wr_fp ? "R4" : "R3") : "R10");
    act = wr_en || rd0_en || rd1_en;
    dom = (wr_en && wr_fp) || (rd0_en && rd0_fp) || (rd1_en && rd1_fp);
    if (act) begin
      if (m_seen && dom != m_last && m_cnt < (1 << CW) - 1) m_cnt++;
      m_seen = 1; m_last = dom;
    end
    m_tag = next_tags(m_tag);
    if (wr_en) m_mem[wr_addr] = wr_data;
    @(posedge clk); @(negedge clk);
    chk(dl0, rd0_data, e_rd0);
    chk(dl1, rd1_data, e_rd1);
    chk(ef ? "R6" : "R7", {63'd0, stack_fault}, {63'd0, ef});
    chk(tl, {56'd0, tag_word}, {56'd0, m_tag});
    chk("R8", {60'd0, switch_count}, 64'(m_cnt));
  endtask

  task automatic idle();
    rd0_en = 0; rd1_en = 0; wr_en = 0; empty_cmd = 0;
  endtask

  task automatic do_wr(bit fp, int a, logic [63:0] d);
    idle(); wr_en = 1; wr_fp = fp; wr_addr = 3'(a); wr_data = d; cycle();
  endtask

  task automatic do_rd(bit fp, int a, bit fp1, int b);
    idle(); rd0_en = 1; rd0_fp = fp; rd0_addr = 3'(a);
    rd1_en = 1; rd1_fp = fp1; rd1_addr = 3'(b); cycle();
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) m_mem[i] = 0;
    m_tag = 0; m_cnt = 0; m_seen = 0; m_last = 0; e_rd0 = 0; e_rd1 = 0;
    repeat (3) @(negedge clk);
    chk("R1", rd0_data, 0); chk("R1", rd1_data, 0);
    chk("R1", {63'd0, stack_fault}, 0);
    chk("R1", {56'd0, tag_word}, 0); chk("R1", {60'd0, switch_count}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {56'd0, tag_word}, 0);

    do_rd(1, 0, 0, 1);                       // R6 empty entry, R7 simd read
    do_wr(1, 2, 64'hDEAD_BEEF_0123_4567);    // R4 single tag
    do_rd(1, 2, 1, 3);                       // R2 hit, R6 miss
    do_wr(0, 5, 64'h8080_8080_8080_8080);    // R3 all tags
    do_rd(1, 5, 1, 2);                       // R2 cross-domain
    idle(); empty_cmd = 1; wr_en = 1; wr_fp = 0; wr_addr = 3'd1;
    wr_data = 64'h1111_2222_3333_4444; cycle(); // R5 clear wins
    do_rd(0, 1, 1, 1);                       // R7 data kept, R6 fault
    idle(); wr_en = 1; wr_fp = 1; wr_addr = 3'd4; wr_data = 64'hABCD;
    rd0_en = 1; rd0_fp = 0; rd0_addr = 3'd4; cycle(); // R2 read-before-write
    idle(); cycle();                         // R9 hold
    for (int k = 0; k < 20; k++) do_rd(k % 2, k % 8, k % 2, (k + 3) % 8); // R8 saturation

    for (int k = 0; k < 3000; k++) begin
      idle();
      wr_en = ($urandom % 3) == 0; wr_fp = $urandom % 2;
      wr_addr = 3'($urandom); wr_data = {$urandom, $urandom};
      rd0_en = ($urandom % 3) != 0; rd0_fp = ($urandom % 4) != 0; rd0_addr = 3'($urandom);
      rd1_en = ($urandom % 2) == 0; rd1_fp = $urandom % 2; rd1_addr = 3'($urandom);
      empty_cmd = ($urandom % 6) == 0;
      cycle();
      if (k == 1500) begin
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        for (int i = 0; i < 8; i++) m_mem[i] = 0;
        m_tag = 0; m_cnt = 0; m_seen = 0; e_rd0 = 0; e_rd1 = 0;
        chk("R1", {56'd0, tag_word}, 0); chk("R1", {60'd0, switch_count}, 0);
        chk("R1", rd0_data, 0);
      end
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule